// File: doc/BRIEF.md
# General-Call Software Reset Detector

This block listens to the byte-level events of a shared two-wire serial bus engine. It recognises the general-call software reset sequence: a START, the all-zero general-call address, one command byte of value 06h, then a STOP. When it sees the whole sequence, it emits a one-cycle reset pulse. A neighbouring port latch uses that pulse to return every I/O to the all-ones (input) state.

The bit engine reports each condition as a one-cycle strobe: START (first or repeated), STOP, a received byte with its value, and the end of the acknowledge slot. While a byte it accepts is awaiting acknowledgement, the detector raises an acknowledge request, and the bit engine drives the acknowledge from it. The detector leaves a byte unacknowledged if it does not belong to the sequence. An unacknowledged step aborts the sequence until the next START.

Top module: `srst_gc_detect`

## Requirements
- R1: After reset, both `ack_req` and `rst_pulse` are 0.
- R2: A byte equal to 00h received as the first byte after a START is acknowledged. `ack_req` is 1 in the cycle after `byte_vld`.
- R3: Any other first byte after a START, including 01h (general call with the read bit set), is not acknowledged. The sequence is then dead until the next START.
- R4: After an acknowledged 00h address, a data byte of 06h is acknowledged.
- R5: After an acknowledged address, a data byte other than 06h is not acknowledged, and a later STOP gives no pulse.
- R6: A STOP arriving directly after the acknowledged 06h byte makes `rst_pulse` 1 in the cycle after `evt_stop`, for exactly one cycle.
- R7: Any byte after the acknowledged 06h is not acknowledged, and a later STOP gives no pulse.
- R8: A repeated START at any point restarts detection from the address byte.
- R9: A STOP without a completed sequence, and bytes received before any START, give neither an acknowledge nor a pulse.
- R10: `ack_req` returns to 0 in the cycle after `ack_slot`, and it is also cleared by a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| evt_start | input | 1 | One-cycle strobe: START or repeated START seen |
| evt_stop | input | 1 | One-cycle strobe: STOP seen |
| byte_vld | input | 1 | One-cycle strobe: a full byte was received |
| byte_data | input | DATA_W | Value of the received byte, valid with `byte_vld` |
| ack_slot | input | 1 | One-cycle strobe: the acknowledge clock of the last byte has ended |
| ack_req | output | 1 | Request to drive an acknowledge for the last byte |
| rst_pulse | output | 1 | One-cycle software reset pulse for the port latch |

## Verification
Both outputs come from registers. `ack_req` reflects a byte one cycle after its `byte_vld` strobe, and it falls one cycle after `ack_slot`. `rst_pulse` is high exactly in the cycle after the `evt_stop` strobe. The bench changes inputs on the falling edge and holds each strobe for one cycle. It reads the outputs at the next falling edge, which falls between the register update and the next input change. To confirm that the pulse is one cycle wide, the bench checks `rst_pulse` again one falling edge later.

// File: rtl/srst_pkg.sv
package srst_pkg;
  // Sequence progress of the general-call reset detector.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // no START seen yet
    ST_ADDR  = 3'd1,  // START seen, expecting address byte
    ST_CMD   = 3'd2,  // general call accepted, expecting command
    ST_ARMED = 3'd3,  // command accepted, expecting STOP
    ST_DEAD  = 3'd4   // aborted until next START
  } srst_state_e;
endpackage

// File: rtl/srst_byte_cmp.sv
module srst_byte_cmp #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] CODE = '0
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);
  localparam int unsigned LastBit = DATA_W - 1;

  logic [LastBit:0] bit_eq;

  // Bitwise equality, then reduction.
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    assign bit_eq[gi] = ~(data_i[gi] ^ CODE[gi]);
  end

  assign hit_o = &bit_eq;
endmodule

// File: rtl/srst_seq_fsm.sv
module srst_seq_fsm
  import srst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_start,
  input  logic evt_stop,
  input  logic byte_vld,
  input  logic addr_hit,
  input  logic cmd_hit,
  output logic ack_set,
  output logic rst_pulse
);
  srst_state_e st_q, st_d;
  logic        pulse_q, pulse_d;

  // Next-state logic. START wins over STOP, which wins over a byte.
  always_comb begin
    st_d    = st_q;
    ack_set = 1'b0;
    pulse_d = 1'b0;
    if (evt_start) begin
      st_d = ST_ADDR;
    end else if (evt_stop) begin
      pulse_d = (st_q == ST_ARMED);
      st_d    = ST_IDLE;
    end else if (byte_vld) begin
      unique case (st_q)
        ST_ADDR: begin
          if (addr_hit) begin
            st_d    = ST_CMD;
            ack_set = 1'b1;
          end else begin
            st_d = ST_DEAD;
          end
        end
        ST_CMD: begin
          if (cmd_hit) begin
            st_d    = ST_ARMED;
            ack_set = 1'b1;
          end else begin
            st_d = ST_DEAD;
          end
        end
        ST_ARMED: st_d = ST_DEAD;
        default:  st_d = st_q;
      endcase
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  assign rst_pulse = pulse_q;

  // R6
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  // R6
  pulse_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(evt_stop));

  // R7
  extra_byte_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && byte_vld && !evt_start && !evt_stop) |=> (st_q == ST_DEAD));

  // R8
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> (st_q == ST_ADDR));
endmodule

// File: rtl/srst_ack_hold.sv
module srst_ack_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_set,
  input  logic byte_vld,
  input  logic ack_slot,
  input  logic evt_start,
  input  logic evt_stop,
  output logic ack_req
);
  logic ack_q, ack_d, ack_en;

  // Any bus event updates the request; otherwise it holds.
  assign ack_en = ack_set | byte_vld | ack_slot | evt_start | evt_stop;

  always_comb begin
    ack_d = ack_q;
    if (ack_en) begin
      ack_d = ack_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
    end
  end

  assign ack_req = ack_q;

  // R10
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && !byte_vld) |=> !ack_req);

  // R10
  ack_bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start || evt_stop) |=> !ack_req);

  // R2
  ack_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(byte_vld));
endmodule

// File: rtl/srst_gc_detect.sv
module srst_gc_detect #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] GC_CODE  = 8'h00,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_start,
  input  logic              evt_stop,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              ack_slot,
  output logic              ack_req,
  output logic              rst_pulse
);
  logic addr_hit, cmd_hit, ack_set;

  srst_byte_cmp #(.DATA_W(DATA_W), .CODE(GC_CODE)) u_addr_cmp (
    .data_i (byte_data),
    .hit_o  (addr_hit)
  );

  srst_byte_cmp #(.DATA_W(DATA_W), .CODE(CMD_CODE)) u_cmd_cmp (
    .data_i (byte_data),
    .hit_o  (cmd_hit)
  );

  srst_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .byte_vld  (byte_vld),
    .addr_hit  (addr_hit),
    .cmd_hit   (cmd_hit),
    .ack_set   (ack_set),
    .rst_pulse (rst_pulse)
  );

  srst_ack_hold u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_set   (ack_set),
    .byte_vld  (byte_vld),
    .ack_slot  (ack_slot),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .ack_req   (ack_req)
  );

  // R9
  no_pulse_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_pulse && ack_req));
endmodule

// File: tb/sim_srst_gc_detect.sv
module sim_srst_gc_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_start = 1'b0, evt_stop = 1'b0, byte_vld = 1'b0, ack_slot = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       ack_req, rst_pulse;
  int         checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  srst_gc_detect u0 (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
    .byte_vld(byte_vld), .byte_data(byte_data), .ack_slot(ack_slot),
    .ack_req(ack_req), .rst_pulse(rst_pulse)
  );

  localparam logic [1:0] KS = 2'd0, KP = 2'd1, KB = 2'd2, KA = 2'd3;
  localparam int NV = 37;
  // {req[3:0], kind[1:0], data[7:0], exp_ack, exp_pulse}
  localparam logic [15:0] VEC [NV] = '{
    {4'd8, KS, 8'h00, 1'b0, 1'b0},
    {4'd2, KB, 8'h00, 1'b1, 1'b0},   // R2
    {4'd10, KA, 8'h00, 1'b0, 1'b0},  // R10
    {4'd4, KB, 8'h06, 1'b1, 1'b0},   // R4
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd6, KP, 8'h00, 1'b0, 1'b1},   // R6
    {4'd8, KS, 8'h00, 1'b0, 1'b0},
    {4'd3, KB, 8'h01, 1'b0, 1'b0},   // R3 read bit set
    {4'd3, KA, 8'h00, 1'b0, 1'b0},
    {4'd3, KB, 8'h06, 1'b0, 1'b0},
    {4'd3, KA, 8'h00, 1'b0, 1'b0},
    {4'd3, KP, 8'h00, 1'b0, 1'b0},
    {4'd8, KS, 8'h00, 1'b0, 1'b0},
    {4'd2, KB, 8'h00, 1'b1, 1'b0},
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd5, KB, 8'h07, 1'b0, 1'b0},   // R5
    {4'd5, KA, 8'h00, 1'b0, 1'b0},
    {4'd5, KP, 8'h00, 1'b0, 1'b0},
    {4'd8, KS, 8'h00, 1'b0, 1'b0},
    {4'd2, KB, 8'h00, 1'b1, 1'b0},
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd4, KB, 8'h06, 1'b1, 1'b0},
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd7, KB, 8'h06, 1'b0, 1'b0},   // R7
    {4'd7, KA, 8'h00, 1'b0, 1'b0},
    {4'd7, KP, 8'h00, 1'b0, 1'b0},
    {4'd8, KS, 8'h00, 1'b0, 1'b0},
    {4'd2, KB, 8'h00, 1'b1, 1'b0},
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd4, KB, 8'h06, 1'b1, 1'b0},
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd8, KS, 8'h00, 1'b0, 1'b0},   // R8 repeated START
    {4'd8, KB, 8'h00, 1'b1, 1'b0},
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd8, KB, 8'h06, 1'b1, 1'b0},
    {4'd10, KA, 8'h00, 1'b0, 1'b0},
    {4'd8, KP, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Drive one strobe for one cycle; return at the falling edge after it is consumed.
  task automatic step(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    evt_start = (k == KS);
    evt_stop  = (k == KP);
    byte_vld  = (k == KB);
    ack_slot  = (k == KA);
    byte_data = d;
    @(negedge clk);
    evt_start = 1'b0; evt_stop = 1'b0; byte_vld = 1'b0; ack_slot = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "ack_req in reset", ack_req, 1'b0);
    chk(1, "rst_pulse in reset", rst_pulse, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, "ack_req after reset", ack_req, 1'b0);

    // R9 bytes and stop before any START
    step(KB, 8'h00);
    chk(9, "ack for byte before START", ack_req, 1'b0);
    step(KB, 8'h06);
    step(KP, 8'h00);
    chk(9, "pulse on bare STOP", rst_pulse, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:10], VEC[i][9:2]);
      chk(int'(VEC[i][15:12]), $sformatf("vec %0d ack_req", i), ack_req, VEC[i][1]);
      chk(int'(VEC[i][15:12]), $sformatf("vec %0d rst_pulse", i), rst_pulse, VEC[i][0]);
    end
    @(negedge clk);
    chk(6, "pulse width one cycle", rst_pulse, 1'b0);

    // R10 START clears a pending acknowledge
    step(KS, 8'h00);
    step(KB, 8'h00);
    chk(10, "ack pending", ack_req, 1'b1);
    step(KS, 8'h00);
    chk(10, "START clears ack", ack_req, 1'b0);
    // R10 STOP clears a pending acknowledge, and no pulse from CMD phase (R5)
    step(KB, 8'h00);
    step(KP, 8'h00);
    chk(10, "STOP clears ack", ack_req, 1'b0);
    chk(5, "no pulse from command phase", rst_pulse, 1'b0);
    // R8 START directly after acked 06h, then STOP: no pulse
    step(KS, 8'h00); step(KB, 8'h00); step(KA, 8'h00);
    step(KB, 8'h06); step(KA, 8'h00); step(KS, 8'h00); step(KP, 8'h00);
    chk(8, "restart drops armed state", rst_pulse, 1'b0);
    // R1 reset in armed state clears progress
    step(KS, 8'h00); step(KB, 8'h00); step(KA, 8'h00); step(KB, 8'h06);
    rst_n = 1'b0;
    @(negedge clk);
    chk(1, "ack cleared by reset", ack_req, 1'b0);
    rst_n = 1'b1;
    step(KP, 8'h00);
    chk(1, "no pulse after reset", rst_pulse, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule